// File: doc/BRIEF.md
# Register Valid-Bit Interlock

This block is the issue interlock of an in-order five-stage pipeline: fetch, decode and register read, execute or address generation, memory access, writeback. It keeps one valid bit for each architectural register. A bit at 0 marks a register whose new value is still in flight, because an issued instruction will write it and has not yet reached writeback.

Decode presents an issue attempt with two source indices and an optional destination index. The block raises `stall_o` when any register the instruction names is pending. Decode then holds the instruction, fetch holds, and a bubble goes into execute. Because the destination is checked as well as the sources, the block also stalls on output and name conflicts, not only on true dependences. When the instruction issues, its destination bit clears. The writeback port sets the bit again. A writeback in the same cycle as the check is seen by decode in that cycle.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every register is valid, so the first issue attempt with any indices does not stall.
- R2: An issued instruction with `dst_we_i`=1 and a nonzero destination makes that register pending. A later attempt that reads it on `src_a_i` or `src_b_i` stalls until it is written back.
- R3: An attempt whose destination (`dst_we_i`=1) is a pending register stalls, even when both of its sources are valid.
- R4: A writeback with `wb_we_i`=1 marks `wb_dst_i` valid from the next cycle onward.
- R5: A writeback to a register in the same cycle as an attempt that names it counts as valid for that attempt.
- R6: Register index 0 never stalls an attempt and is never made pending.
- R7: An attempt with `dst_we_i`=0 makes no register pending.
- R8: A stalled attempt makes no register pending. The destination goes pending only in the cycle the attempt issues (`issue_req_i`=1 and `stall_o`=0).
- R9: With `issue_req_i`=0, `stall_o` is 0 and no register goes pending.
- R10: When an issue and a writeback name the same destination in one cycle, the register ends pending, because the new writer is the newer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, makes all registers valid |
| issue_req_i | input | 1 | Decode holds an instruction trying to issue |
| src_a_i | input | IDX_W | First source register index |
| src_b_i | input | IDX_W | Second source register index |
| dst_i | input | IDX_W | Destination register index |
| dst_we_i | input | 1 | The instruction writes `dst_i` |
| wb_we_i | input | 1 | Writeback writes a register this cycle |
| wb_dst_i | input | IDX_W | Writeback register index |
| stall_o | output | 1 | Hold fetch and decode, insert a bubble |

## Verification
Directed sequences separate the cases one at a time. A read-after-write on each source port checks the source checks. A write-after-write with valid sources isolates the destination check. A reader paired with a same-cycle writeback shows the bypass. Repeated stalled attempts confirm that only a real issue clears a bit, and a simultaneous issue and writeback to one register shows which of the two wins. Random traffic over a small index range then keeps many registers pending at once, and every cycle is compared with a behavioural model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  typedef logic [IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/sb_valid_bits.sv
module sb_valid_bits #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_en_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  output logic [NUM_REGS-1:0] eff_valid_o
);
  logic [NUM_REGS-1:0] valid_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
    if (r == 0) begin : g_zero
      assign valid_q[r]     = 1'b1;
      assign eff_valid_o[r] = 1'b1;
    end else begin : g_reg
      logic hit_set, hit_clr;
      assign hit_set = set_en_i && (set_idx_i == IDX_W'(r));
      assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(r));
      // writeback seen by decode in the same cycle
      assign eff_valid_o[r] = valid_q[r] | hit_set;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      valid_q[r] <= 1'b1;
        else if (hit_clr) valid_q[r] <= 1'b0; // newer writer wins
        else if (hit_set) valid_q[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] eff_valid_i,
  input  logic                issue_req_i,
  input  logic [IDX_W-1:0]    src_a_i,
  input  logic [IDX_W-1:0]    src_b_i,
  input  logic [IDX_W-1:0]    dst_i,
  input  logic                dst_we_i,
  output logic                stall_o,
  output logic                clr_en_o
);
  logic busy_a, busy_b, busy_d;

  always_comb begin
    busy_a   = !eff_valid_i[src_a_i];
    busy_b   = !eff_valid_i[src_b_i];
    busy_d   = dst_we_i && !eff_valid_i[dst_i];
    stall_o  = issue_req_i && (busy_a || busy_b || busy_d);
    clr_en_o = issue_req_i && !stall_o && dst_we_i && (dst_i != '0);
  end
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_req_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic             dst_we_i,
  input  logic             wb_we_i,
  input  logic [IDX_W-1:0] wb_dst_i,
  output logic             stall_o
);
  logic [NUM_REGS-1:0] eff_valid;
  logic                clr_en;

  sb_valid_bits #(.NUM_REGS(NUM_REGS)) i_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_en_i    (clr_en),
    .clr_idx_i   (dst_i),
    .set_en_i    (wb_we_i),
    .set_idx_i   (wb_dst_i),
    .eff_valid_o (eff_valid)
  );

  sb_issue_check #(.NUM_REGS(NUM_REGS)) i_check (
    .eff_valid_i (eff_valid),
    .issue_req_i (issue_req_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .dst_i       (dst_i),
    .dst_we_i    (dst_we_i),
    .stall_o     (stall_o),
    .clr_en_o    (clr_en)
  );
endmodule

// File: rtl/reg_scoreboard_checker.sv
module reg_scoreboard_checker #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_req_i,
  input logic [IDX_W-1:0] src_a_i,
  input logic [IDX_W-1:0] src_b_i,
  input logic [IDX_W-1:0] dst_i,
  input logic             dst_we_i,
  input logic             wb_we_i,
  input logic [IDX_W-1:0] wb_dst_i,
  input logic             stall_o
);
  logic issued;
  assign issued = issue_req_i && !stall_o && dst_we_i && (dst_i != '0);

  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_req_i |-> !stall_o); // R9

  AST_ZERO_NEVER_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_req_i && src_a_i == '0 && src_b_i == '0 && (!dst_we_i || dst_i == '0))
    |-> !stall_o); // R6

  AST_RAW_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issued ##1 (issue_req_i && src_a_i == $past(dst_i) &&
                !(wb_we_i && wb_dst_i == src_a_i)) |-> stall_o); // R2

  AST_WAW_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issued ##1 (issue_req_i && dst_we_i && dst_i == $past(dst_i) &&
                !(wb_we_i && wb_dst_i == dst_i)) |-> stall_o); // R3

  AST_WB_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_req_i && wb_we_i && wb_dst_i == src_a_i && src_b_i == '0 &&
     (!dst_we_i || dst_i == '0)) |-> !stall_o); // R5
endmodule

bind reg_scoreboard reg_scoreboard_checker #(.NUM_REGS(NUM_REGS)) i_checker (.*);

// File: tb/test_reg_scoreboard.sv
module test_reg_scoreboard;
  localparam int NUM_REGS = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic issue_req = 0, dst_we = 0, wb_we = 0;
  logic [IDX_W-1:0] src_a = 0, src_b = 0, dst = 0, wb_dst = 0;
  logic stall;

  int checks = 0, errors = 0;
  bit model_valid [NUM_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_scoreboard #(.NUM_REGS(NUM_REGS)) i_reg_scoreboard (
    .clk_i(clk), .rst_ni(rst_n), .issue_req_i(issue_req),
    .src_a_i(src_a), .src_b_i(src_b), .dst_i(dst), .dst_we_i(dst_we),
    .wb_we_i(wb_we), .wb_dst_i(wb_dst), .stall_o(stall));

  function automatic bit ready(int r, bit wbe, int wbd);
    if (r == 0) return 1;
    if (wbe && wbd == r) return 1;
    return model_valid[r];
  endfunction

  // one cycle: drive after negedge, compare before posedge, update model
  task automatic step(string tag, bit req, int a, int b, int d, bit dwe,
                      bit wbe, int wbd, int exp_force = -1);
    bit exp_stall;
    @(negedge clk);
    issue_req = req; src_a = IDX_W'(a); src_b = IDX_W'(b); dst = IDX_W'(d);
    dst_we = dwe; wb_we = wbe; wb_dst = IDX_W'(wbd);
    exp_stall = req && !(ready(a, wbe, wbd) && ready(b, wbe, wbd) &&
                         (!dwe || ready(d, wbe, wbd)));
    #(CLK_PERIOD/2 - 1);
    checks++;
    if (exp_force >= 0 && exp_force != int'(exp_stall)) begin
      errors++;
      $display("FAIL %s: model expectation %0d, requirement %0d", tag, exp_stall, exp_force);
    end
    if (stall !== exp_stall) begin
      errors++;
      $display("FAIL %s: stall_o=%b expected %b", tag, stall, exp_stall);
    end
    @(posedge clk);
    if (wbe && wbd != 0) model_valid[wbd] = 1;
    if (req && !exp_stall && dwe && d != 0) model_valid[d] = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NUM_REGS; r++) model_valid[r] = 1;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: everything valid after reset
    step("R1", 1, 5, 6, 7, 1, 0, 0, 0);          // issues, r7 pending
    // R2: read pending r7 on port a, then port b
    step("R2", 1, 7, 1, 0, 0, 0, 0, 1);
    step("R2", 1, 2, 7, 0, 0, 0, 0, 1);
    // R3: write-after-write on r7 with clean sources
    step("R3", 1, 1, 2, 7, 1, 0, 0, 1);
    // R8: repeated stalls clear nothing: r9 stays valid
    step("R8", 1, 7, 0, 9, 1, 0, 0, 1);
    step("R8", 1, 9, 9, 0, 0, 0, 0, 0);
    // R9: idle with pending register
    step("R9", 0, 7, 7, 7, 1, 0, 0, 0);
    step("R9", 1, 7, 0, 0, 0, 0, 0, 1);           // idle cleared nothing more
    // R5: same-cycle writeback bypass
    step("R5", 1, 7, 0, 0, 0, 1, 7, 0);
    // R4: r7 valid afterwards
    step("R4", 1, 7, 7, 7, 0, 0, 0, 0);
    // R7: no-destination instruction names r12, r12 stays valid
    step("R7", 1, 0, 0, 12, 0, 0, 0, 0);
    step("R7", 1, 12, 12, 12, 1, 0, 0, 0);        // r12 now pending
    step("R2", 1, 12, 0, 0, 0, 0, 0, 1);
    // R10: issue writes r12 while writeback of r12 happens
    step("R10", 1, 0, 0, 12, 1, 1, 12, 0);
    step("R10", 1, 12, 0, 0, 0, 0, 0, 1);
    step("R4", 1, 12, 0, 0, 0, 1, 12, 0);
    // R6: register 0 never pending
    step("R6", 1, 0, 0, 0, 1, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 1, 0, 0, 0);
    // random traffic over a small range
    for (int i = 0; i < 3000; i++) begin
      step("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) != 0, $urandom_range(0, 7));
    end
    // R1: reset again restores all bits
    @(negedge clk); rst_n = 0;
    for (int r = 0; r < NUM_REGS; r++) model_valid[r] = 1;
    @(negedge clk); rst_n = 1;
    step("R1", 1, 1, 2, 3, 1, 0, 0, 0);
    step("R1", 1, 4, 5, 6, 1, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule